// File: doc/BRIEF.md
# Bit-Serial Memory Delay Line Controller

This controller turns a row/column-addressed one-bit memory into a circular delay line for a single-bit sample stream. Each sample, marked by a one-cycle `sample_tick` on the fast system clock, starts one fixed access. The access presents a row address and drops RAS, then presents a column address and drops CAS. It latches the stored bit as the new output, writes the incoming bit to the same cell, and releases both strobes. The address advances by one after every sample, so every cell is revisited exactly once per trip around the address space.

The address comes from a chain of small cascaded counter stages. The low half of the count forms the row, so consecutive samples step through every row, and the sequential sweep also serves as refresh. The delay in samples is fixed by the size of the address space. The delay in time is set only by how often `sample_tick` arrives. The serial output can drive the input of a second controller to lengthen the line.

Top module: `bitdelay_dram_ctl`

## Requirements
- R1: While `rst_n` is low, `mem_ras_n`, `mem_cas_n` and `mem_we_n` are high, `dout` is 0 and the address count is 0.
- R2: A `sample_tick` seen while idle starts exactly one access, with one RAS pulse. A tick arriving while an access is under way is ignored and does not start or disturb any access.
- R3: Within an access, the row is on `mem_addr` when RAS falls, and the column is on `mem_addr` when CAS falls. CAS is low only while RAS is low, and WE is low only while CAS is low. The address stays stable while CAS is low, and both strobes are high again before the next access.
- R4: The address is a count of `NSTAGES` cascaded `STAGE_W`-bit stages. It increases by one after each access and wraps from all ones to 0.
- R5: The row is the low `ROW_W` bits of the count and the column is the remaining high bits. Both are driven onto the low bits of `mem_addr`, with any unused upper bits at 0.
- R6: `din` is sampled in the cycle where the accepted `sample_tick` is high.
- R7: After access k (counted from 0 since reset), `dout` equals the `din` of access k−D, where D = 2^(STAGE_W·NSTAGES). Before D accesses have occurred, `dout` shows the initial memory content.
- R8: Two controllers sharing `sample_tick`, with the first `dout` driving the second `din`, delay the stream by 2D+1 samples.
- R9: `dout` changes only on the clock edge that ends a cycle in which CAS was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse that starts a sample access |
| din | input | 1 | Incoming serial bit |
| dout | output | 1 | Delayed serial bit |
| mem_addr | output | MUX_W | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_d | output | 1 | Bit written to memory |
| mem_q | input | 1 | Bit read from memory |

## Verification
The hardest case to reach is the wrap of the address count. It only occurs after every cell has been visited, and it is the only point where the delayed bits show that no cell is skipped or reused. The bench builds the controller with three 2-bit stages, giving a 64-sample line. It streams several hundred samples through two chained controllers, so that the single line wraps several times and the chained line wraps at least once. Stray ticks are injected in the middle of accesses to show that they are ignored. The row and column are captured at each strobe to compare against the sample index.

// File: rtl/bitdelay_dram_ctl.sv
module bitdelay_dram_ctl #(
  parameter int STAGE_W = 4,
  parameter int NSTAGES = 4,
  localparam int ADDR_W = STAGE_W * NSTAGES,
  localparam int ROW_W  = ADDR_W / 2,
  localparam int COL_W  = ADDR_W - ROW_W,
  localparam int MUX_W  = COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             din,
  output logic             dout,
  output logic [MUX_W-1:0] mem_addr,
  output logic             mem_ras_n,
  output logic             mem_cas_n,
  output logic             mem_we_n,
  output logic             mem_d,
  input  logic             mem_q
);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_RAS, S_COL, S_CAS, S_LATCH, S_WE, S_REL
  } phase_t;

  phase_t phase;
  logic [ADDR_W-1:0] cnt;
  logic [NSTAGES:0]  carry;
  logic              bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= S_IDLE;
      bit_in <= 1'b0;
      dout   <= 1'b0;
    end else begin
      case (phase)
        S_IDLE:  if (sample_tick) begin
                   phase  <= S_ROW;
                   bit_in <= din;
                 end
        S_ROW:   phase <= S_RAS;
        S_RAS:   phase <= S_COL;
        S_COL:   phase <= S_CAS;
        S_CAS:   phase <= S_LATCH;
        S_LATCH: begin
                   phase <= S_WE;
                   dout  <= mem_q;
                 end
        S_WE:    phase <= S_REL;
        default: phase <= S_IDLE;
      endcase
    end
  end

  assign carry[0] = (phase == S_REL);

  for (genvar g = 0; g < NSTAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[g*STAGE_W +: STAGE_W] <= '0;
      else if (carry[g])
        cnt[g*STAGE_W +: STAGE_W] <= cnt[g*STAGE_W +: STAGE_W] + 1'b1;
    end
    assign carry[g+1] = carry[g] && (&cnt[g*STAGE_W +: STAGE_W]);
  end

  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             col_phase;

  assign row       = cnt[ROW_W-1:0];
  assign col       = cnt[ADDR_W-1:ROW_W];
  assign col_phase = (phase == S_COL) || (phase == S_CAS) || (phase == S_LATCH) ||
                     (phase == S_WE)  || (phase == S_REL);
  assign mem_addr  = col_phase ? MUX_W'(col) : MUX_W'(row);

  assign mem_ras_n = !((phase == S_RAS) || (phase == S_COL) || (phase == S_CAS) ||
                       (phase == S_LATCH) || (phase == S_WE));
  assign mem_cas_n = !((phase == S_CAS) || (phase == S_LATCH) || (phase == S_WE));
  assign mem_we_n  = !(phase == S_WE);
  assign mem_d     = bit_in;

endmodule

// File: rtl/bitdelay_dram_ctl_chk.sv
module bitdelay_dram_ctl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_ras_n,
  input logic          mem_cas_n,
  input logic          mem_we_n,
  input logic          dout,
  input logic [AW-1:0] mem_addr
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (mem_ras_n && mem_cas_n && mem_we_n && !dout)));

  // R3
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n |-> !mem_ras_n);

  // R3
  we_in_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cas_n);

  // R3
  ras_before_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> $past(!mem_ras_n));

  // R3
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cas_n && $past(!mem_cas_n)) |-> $stable(mem_addr));

  // R2
  single_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ras_n) |=> mem_ras_n);

  // R9
  dout_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(!mem_cas_n));

endmodule

bind bitdelay_dram_ctl bitdelay_dram_ctl_chk #(.AW(MUX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
  .mem_we_n(mem_we_n), .dout(dout), .mem_addr(mem_addr)
);

// File: tb/bitdelay_dram_ctl_test.sv
module bitdelay_mem_model #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int MUX_W = 3
) (
  input  logic             clk,
  input  logic [MUX_W-1:0] addr,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             d,
  output logic             q
);
  logic             cells [0:(1<<(ROW_W+COL_W))-1];
  logic [ROW_W-1:0] row_l;
  logic             ras_q;

  initial begin
    for (int i = 0; i < (1<<(ROW_W+COL_W)); i++) cells[i] = 1'b0;
    row_l = '0;
    ras_q = 1'b1;
  end

  always @(posedge clk) begin
    ras_q <= ras_n;
    if (ras_q && !ras_n) row_l <= addr[ROW_W-1:0];
    if (!we_n && !cas_n) cells[{row_l, addr[COL_W-1:0]}] <= d;
  end

  assign q = cas_n ? 1'b0 : cells[{row_l, addr[COL_W-1:0]}];
endmodule

module bitdelay_dram_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 2;
  localparam int NS = 3;
  localparam int AW = SW * NS;
  localparam int RW = AW / 2;
  localparam int CW = AW - RW;
  localparam int D  = 1 << AW;
  localparam int NSAMP = 450;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, din = 1'b0;
  logic dout, dout2, q1, q2, ras1, cas1, we1, d1, ras2, cas2, we2, d2;
  logic [CW-1:0] a1, a2;
  logic xs [0:NSAMP-1];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitdelay_dram_ctl #(.STAGE_W(SW), .NSTAGES(NS)) uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .din(din), .dout(dout),
    .mem_addr(a1), .mem_ras_n(ras1), .mem_cas_n(cas1), .mem_we_n(we1),
    .mem_d(d1), .mem_q(q1));
  bitdelay_mem_model #(.ROW_W(RW), .COL_W(CW), .MUX_W(CW)) mem1 (
    .clk(clk), .addr(a1), .ras_n(ras1), .cas_n(cas1), .we_n(we1), .d(d1), .q(q1));

  bitdelay_dram_ctl #(.STAGE_W(SW), .NSTAGES(NS)) uut2 (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .din(dout), .dout(dout2),
    .mem_addr(a2), .mem_ras_n(ras2), .mem_cas_n(cas2), .mem_we_n(we2),
    .mem_d(d2), .mem_q(q2));
  bitdelay_mem_model #(.ROW_W(RW), .COL_W(CW), .MUX_W(CW)) mem2 (
    .clk(clk), .addr(a2), .ras_n(ras2), .cas_n(cas2), .we_n(we2), .d(d2), .q(q2));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_sample(input int k, input bit stray);
    din = xs[k]; tick = 1'b1;
    @(negedge clk); tick = 1'b0; din = ~xs[k];   // N1: state ROW
    @(negedge clk);                              // N2: RAS low, row shown
    check("R5 row", int'(a1), k % (1 << RW));
    check("R3 ras low", int'(ras1), 0);
    check("R3 cas high", int'(cas1), 1);
    @(negedge clk);                              // N3
    if (stray) tick = 1'b1;
    @(negedge clk); tick = 1'b0;                 // N4: CAS low, column shown
    check("R4 R5 col", int'(a1), (k >> RW) % (1 << CW));
    check("R3 cas low", int'(cas1), 0);
    repeat (5) @(negedge clk);                   // N9: idle again
    check("R2 strobes released", int'({ras1, cas1, we1}), 7);
    check("R7 dout", int'(dout), (k >= D) ? int'(xs[k-D]) : 0);
    check("R8 chained dout", int'(dout2), (k >= 2*D+1) ? int'(xs[k-2*D-1]) : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int k = 0; k < NSAMP; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (k >= 150 && k < 220)      xs[k] = 1'b1;
      else if (k >= 300 && k < 340) xs[k] = k[0];
      else                          xs[k] = lf[0];
    end
    din = 1'b1;
    tick = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset holds strobes high and output low despite tick
    check("R1 ras_n", int'(ras1), 1);
    check("R1 cas_n", int'(cas1), 1);
    check("R1 we_n", int'(we1), 1);
    check("R1 dout", int'(dout), 0);
    check("R1 row addr", int'(a1), 0);
    tick = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 idle without tick", int'(ras1), 1);
    for (int k = 0; k < NSAMP; k++) do_sample(k, (k % 7) == 3);
    // R6: din changed after tick must not reach memory; covered by R7 checks
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule